// File: doc/BRIEF.md
# Cluster Global Control Register Block

This block is the global control and status register file of a multi-core cluster. It sits on a simple register bus with a byte address, a 64-bit write word, and separate write and read strobes. It answers a small set of global offsets, a core-local configuration window and a core-other configuration window. Almost every register is a constant or comes from a strap. The exception is one writable register that places and enables the register window of a companion power controller.

The stored value of that register drives a remap base and a window enable to an external address decoder. That decoder moves the power-controller window around the address map while the system runs. A write to it is accepted only while the presence strap says the power controller is fitted. Any access the block does not implement returns zero and raises a one-cycle indication.

Offsets (byte addresses, matched exactly; all other addresses are unmapped):

| Offset | Contents |
|---|---|
| 0x0000 | global configuration |
| 0x0008 | self base |
| 0x0030 | revision |
| 0x0088 | power-controller base (writable) |
| 0x00F0 | power-controller status |
| 0x0130 | L2 configuration |
| 0x2010 | core configuration, local window |
| 0x2018 | core-other select |
| 0x4010 | core configuration, other window |

Top module: `cluster_ctl_regs`

## Requirements
- R1: A write to offset 0x0088 while `pwrCtlPresent` is 1 stores the write word ANDed with the writable mask. The mask keeps bit 0 (enable) and bits 47:15 (base) and clears every other bit. A later read of 0x0088 returns the stored value.
- R2: A write to offset 0x0088 while `pwrCtlPresent` is 0 leaves the stored value, `remapBase` and `remapEn` unchanged, and raises no `unimplPulse`.
- R3: `remapBase` carries bits 47:15 of the stored value and is zero in bits 14:0 and 63:48. `remapEn` equals stored bit 0. Both outputs change on the clock edge that accepts the write.
- R4: During and after reset, the stored value is zero, so `remapEn` is 0. `remapBase`, `busRdata` and `unimplPulse` are also 0.
- R5: A read of offset 0x00F0 returns 1 when `pwrCtlPresent` is 1 and 0 when it is 0.
- R6: Offset 0x0000 reads 0 (a core count of zero). Offset 0x0030 reads `REV_VALUE` (default 0x800). Offset 0x0008 reads `SELF_BASE`.
- R7: Offset 0x0130 reads a word in which only bit 20, the bypass bit, is set.
- R8: Offsets 0x2010 and 0x4010 both read `NUM_VP`-1. Offset 0x2018 reads 0.
- R9: A read of an unmapped offset, including an address that is not 8-byte aligned, returns 0. It also raises `unimplPulse` for exactly one cycle.
- R10: A write to any offset other than 0x0088, read-only registers included, changes no state and raises `unimplPulse` for one cycle.
- R11: `busRdata` is registered. It shows the addressed value in the cycle after the read strobe and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| busAddr | input | ADDR_W | byte address of the access |
| busWdata | input | 64 | write word |
| busWr | input | 1 | write strobe |
| busRd | input | 1 | read strobe |
| pwrCtlPresent | input | 1 | strap, 1 when the power controller is fitted |
| busRdata | output | 64 | registered read data |
| unimplPulse | output | 1 | one-cycle flag for an unimplemented access |
| remapBase | output | 64 | base address of the power-controller window |
| remapEn | output | 1 | enable of the power-controller window |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle, because the bus issues one access at a time. They also assume that the presence strap is sampled on the same edge as the access it qualifies. The stimulus drives a single strobe per cycle from a fixed list of mapped and unmapped addresses. It changes the strap only on inactive clock edges, and it sometimes flips the strap between writes to the base register, so that both the accept path and the discard path are exercised.

// File: rtl/cluster_ctl_pkg.sv
package cluster_ctl_pkg;
  localparam logic [15:0] OFS_CFG      = 16'h0000;
  localparam logic [15:0] OFS_SELF     = 16'h0008;
  localparam logic [15:0] OFS_REV      = 16'h0030;
  localparam logic [15:0] OFS_PWRBASE  = 16'h0088;
  localparam logic [15:0] OFS_PWRSTAT  = 16'h00F0;
  localparam logic [15:0] OFS_L2       = 16'h0130;
  localparam logic [15:0] WIN_LOCAL    = 16'h2000;
  localparam logic [15:0] WIN_OTHER    = 16'h4000;
  localparam logic [15:0] OFS_CORECFG  = 16'h0010;
  localparam logic [15:0] OFS_OTHERSEL = 16'h0018;

  localparam int BASE_LO = 15;
  localparam int BASE_HI = 47;
  localparam int L2_BYPASS_BIT = 20;
  localparam logic [63:0] BASE_FIELD_MSK = ((64'd1 << (BASE_HI + 1)) - 64'd1) & ~((64'd1 << BASE_LO) - 64'd1);
  localparam logic [63:0] EN_MSK = 64'd1;
  localparam logic [63:0] WR_MSK = BASE_FIELD_MSK | EN_MSK;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CFG, SEL_SELF, SEL_REV, SEL_PWRBASE,
    SEL_PWRSTAT, SEL_L2, SEL_CORECFG, SEL_OTHERSEL
  } regSel_e;

  typedef struct packed {
    logic    loadBase;
    logic    capture;
    logic    flagUnimpl;
    regSel_e sel;
  } ctlStrobe_t;
endpackage

// File: rtl/cluster_ctl_ctrl.sv
module cluster_ctl_ctrl
  import cluster_ctl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              pwrCtlPresent,
  output ctlStrobe_t        strobe
);
  regSel_e sel;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [15:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_comb begin
    sel = SEL_NONE;
    if      (hit(busAddr, OFS_CFG))                  sel = SEL_CFG;
    else if (hit(busAddr, OFS_SELF))                 sel = SEL_SELF;
    else if (hit(busAddr, OFS_REV))                  sel = SEL_REV;
    else if (hit(busAddr, OFS_PWRBASE))              sel = SEL_PWRBASE;
    else if (hit(busAddr, OFS_PWRSTAT))              sel = SEL_PWRSTAT;
    else if (hit(busAddr, OFS_L2))                   sel = SEL_L2;
    else if (hit(busAddr, WIN_LOCAL + OFS_CORECFG))  sel = SEL_CORECFG;
    else if (hit(busAddr, WIN_OTHER + OFS_CORECFG))  sel = SEL_CORECFG;
    else if (hit(busAddr, WIN_LOCAL + OFS_OTHERSEL)) sel = SEL_OTHERSEL;
  end

  always_comb begin
    strobe.sel        = sel;
    strobe.capture    = busRd;
    strobe.loadBase   = busWr && (sel == SEL_PWRBASE) && pwrCtlPresent;
    strobe.flagUnimpl = (busRd && (sel == SEL_NONE)) ||
                        (busWr && (sel != SEL_PWRBASE));
  end
endmodule

// File: rtl/cluster_ctl_dp.sv
module cluster_ctl_dp
  import cluster_ctl_pkg::*;
#(
  parameter int          NUM_VP    = 4,
  parameter logic [63:0] REV_VALUE = 64'h800,
  parameter logic [63:0] SELF_BASE = 64'h1FBF_8000
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobe_t  strobe,
  input  logic [63:0] busWdata,
  input  logic        pwrCtlPresent,
  output logic [63:0] busRdata,
  output logic        unimplPulse,
  output logic [63:0] remapBase,
  output logic        remapEn
);
  localparam logic [63:0] VP_FIELD = 64'(NUM_VP - 1);
  localparam logic [63:0] L2_WORD  = 64'd1 << L2_BYPASS_BIT;

  logic [63:0] baseReg;
  logic [63:0] readMux;

  always_ff @(posedge clk) begin
    if (!rstN)                baseReg <= '0 & WR_MSK;
    else if (strobe.loadBase) baseReg <= busWdata & WR_MSK;
  end

  always_comb begin
    unique case (strobe.sel)
      SEL_SELF:     readMux = SELF_BASE;
      SEL_REV:      readMux = REV_VALUE;
      SEL_PWRBASE:  readMux = baseReg;
      SEL_PWRSTAT:  readMux = {63'd0, pwrCtlPresent};
      SEL_L2:       readMux = L2_WORD;
      SEL_CORECFG:  readMux = VP_FIELD;
      default:      readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata    <= '0;
      unimplPulse <= 1'b0;
    end else begin
      unimplPulse <= strobe.flagUnimpl;
      if (strobe.capture) busRdata <= readMux;
    end
  end

  assign remapBase = baseReg & BASE_FIELD_MSK;
  assign remapEn   = baseReg[0];
endmodule

// File: rtl/cluster_ctl_regs.sv
module cluster_ctl_regs
  import cluster_ctl_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          NUM_VP    = 4,
  parameter logic [63:0] REV_VALUE = 64'h800,
  parameter logic [63:0] SELF_BASE = 64'h1FBF_8000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [63:0]       busWdata,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              pwrCtlPresent,
  output logic [63:0]       busRdata,
  output logic              unimplPulse,
  output logic [63:0]       remapBase,
  output logic              remapEn
);
  ctlStrobe_t strobe;

  cluster_ctl_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .pwrCtlPresent(pwrCtlPresent), .strobe(strobe)
  );

  cluster_ctl_dp #(.NUM_VP(NUM_VP), .REV_VALUE(REV_VALUE), .SELF_BASE(SELF_BASE)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .pwrCtlPresent(pwrCtlPresent), .busRdata(busRdata), .unimplPulse(unimplPulse),
    .remapBase(remapBase), .remapEn(remapEn)
  );
endmodule

// File: rtl/cluster_ctl_chk.sv
module cluster_ctl_chk
  import cluster_ctl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic              pwrCtlPresent,
  input logic [63:0]       busRdata,
  input logic              unimplPulse,
  input logic [63:0]       remapBase,
  input logic              remapEn
);
  logic baseHit;
  assign baseHit = busAddr == ADDR_W'(OFS_PWRBASE);

  // R2
  discard_absent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && baseHit && !pwrCtlPresent) |=> ($stable(remapBase) && $stable(remapEn) && !unimplPulse));

  // R3
  remap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && baseHit && pwrCtlPresent) |=> ($stable(remapBase) && $stable(remapEn)));

  // R3
  remap_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    (remapBase[14:0] == 15'd0) && (remapBase[63:48] == 16'd0));

  // R5
  status_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == ADDR_W'(OFS_PWRSTAT)) |=> (busRdata == {63'd0, $past(pwrCtlPresent)}));

  // R10
  bad_write_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !baseHit) |=> unimplPulse);

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> $stable(busRdata));

  // R9
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd || busWr) |=> !unimplPulse);
endmodule

bind cluster_ctl_regs cluster_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
  .pwrCtlPresent(pwrCtlPresent), .busRdata(busRdata), .unimplPulse(unimplPulse),
  .remapBase(remapBase), .remapEn(remapEn)
);

// File: tb/sim_cluster_ctl_regs.sv
`timescale 1ns/1ps
module sim_cluster_ctl_regs;
  localparam int AW = 16;
  localparam logic [63:0] SELFB = 64'h1FBF_8000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [63:0] busWdata = '0;
  logic busWr = 1'b0, busRd = 1'b0, pwrCtlPresent = 1'b1;
  logic [63:0] busRdata, remapBase;
  logic unimplPulse, remapEn;

  int checks = 0, failures = 0;
  bit finished = 0;
  bit modelOn = 0;

  // reference model state
  logic [63:0] mBase = '0, mRdata = '0;
  logic mUnimpl = 1'b0;

  always #4 clk = ~clk;

  cluster_ctl_regs u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata), .busWr(busWr),
    .busRd(busRd), .pwrCtlPresent(pwrCtlPresent), .busRdata(busRdata),
    .unimplPulse(unimplPulse), .remapBase(remapBase), .remapEn(remapEn)
  );

  function automatic logic [64:0] expRead(input logic [AW-1:0] a, input logic pres, input logic [63:0] b);
    case (a)
      16'h0000: return {1'b1, 64'd0};
      16'h0008: return {1'b1, SELFB};
      16'h0030: return {1'b1, 64'h800};
      16'h0088: return {1'b1, b};
      16'h00F0: return {1'b1, 63'd0, pres};
      16'h0130: return {1'b1, 64'h0010_0000};
      16'h2010: return {1'b1, 64'd3};
      16'h4010: return {1'b1, 64'd3};
      16'h2018: return {1'b1, 64'd0};
      default:  return {1'b0, 64'd0};
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mBase <= '0; mRdata <= '0; mUnimpl <= 1'b0;
    end else begin
      logic [64:0] r;
      r = expRead(busAddr, pwrCtlPresent, mBase);
      mUnimpl <= 1'b0;
      if (busRd) begin
        mRdata <= r[63:0];
        mUnimpl <= !r[64];
      end
      if (busWr) begin
        if (busAddr == 16'h0088) begin
          if (pwrCtlPresent) mBase <= busWdata & 64'h0000_FFFF_FFFF_8001;
        end else mUnimpl <= 1'b1;
      end
    end
  end

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (modelOn && rstN) begin
    check(busRdata, mRdata, "R11 model rdata");
    check({63'd0, unimplPulse}, {63'd0, mUnimpl}, "R9 model unimpl");
    check(remapBase, mBase & 64'h0000_FFFF_FFFF_8000, "R3 model base");
    check({63'd0, remapEn}, {63'd0, mBase[0]}, "R3 model enable");
  end

  task automatic rd(input logic [AW-1:0] a, output logic [63:0] v, output logic u);
    @(negedge clk); busRd = 1'b1; busAddr = a;
    @(negedge clk); busRd = 1'b0; v = busRdata; u = unimplPulse;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [63:0] d, output logic u);
    @(negedge clk); busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWr = 1'b0; u = unimplPulse;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [63:0] v;
    logic u;
    repeat (3) @(negedge clk);
    // R4 reset state
    check(remapBase, 64'd0, "R4 base in reset");
    check({63'd0, remapEn}, 64'd0, "R4 enable in reset");
    check(busRdata, 64'd0, "R4 rdata in reset");
    check({63'd0, unimplPulse}, 64'd0, "R4 unimpl in reset");
    rstN = 1'b1;
    modelOn = 1;

    rd(16'h0000, v, u); check(v, 64'd0, "R6 config");
    rd(16'h0030, v, u); check(v, 64'h800, "R6 revision");
    rd(16'h0008, v, u); check(v, SELFB, "R6 self base");
    rd(16'h0130, v, u); check(v, 64'h0010_0000, "R7 L2 bypass");
    rd(16'h2010, v, u); check(v, 64'd3, "R8 local core config");
    rd(16'h4010, v, u); check(v, 64'd3, "R8 other core config");
    rd(16'h2018, v, u); check(v, 64'd0, "R8 other select");
    rd(16'h00F0, v, u); check(v, 64'd1, "R5 status present");
    pwrCtlPresent = 1'b0;
    rd(16'h00F0, v, u); check(v, 64'd0, "R5 status absent");
    pwrCtlPresent = 1'b1;

    wr(16'h0088, 64'hFFFF_FFFF_FFFF_FFFF, u);
    check(remapBase, 64'h0000_FFFF_FFFF_8000, "R3 base field");
    check({63'd0, remapEn}, 64'd1, "R3 enable set");
    check({63'd0, u}, 64'd0, "R1 no flag on accepted write");
    rd(16'h0088, v, u); check(v, 64'h0000_FFFF_FFFF_8001, "R1 masked readback");

    pwrCtlPresent = 1'b0;
    wr(16'h0088, 64'd0, u);
    check({63'd0, u}, 64'd0, "R2 no flag when absent");
    check({63'd0, remapEn}, 64'd1, "R2 enable kept");
    pwrCtlPresent = 1'b1;
    rd(16'h0088, v, u); check(v, 64'h0000_FFFF_FFFF_8001, "R2 value kept");

    wr(16'h0088, 64'h1234_5678_9ABC_DEF0, u);
    check(remapBase, 64'h0000_5678_9ABC_8000, "R3 base pattern");
    check({63'd0, remapEn}, 64'd0, "R3 enable cleared");
    rd(16'h0088, v, u); check(v, 64'h0000_5678_9ABC_8000, "R1 pattern readback");

    wr(16'h0030, 64'hDEAD, u); check({63'd0, u}, 64'd1, "R10 write to revision flagged");
    rd(16'h0030, v, u); check(v, 64'h800, "R10 revision unchanged");
    wr(16'h0200, 64'hFFFF, u); check({63'd0, u}, 64'd1, "R10 write unmapped flagged");
    check(remapBase, 64'h0000_5678_9ABC_8000, "R10 base unchanged");

    rd(16'h0100, v, u);
    check(v, 64'd0, "R9 unmapped zero"); check({63'd0, u}, 64'd1, "R9 unmapped flag");
    @(negedge clk); check({63'd0, unimplPulse}, 64'd0, "R9 single cycle");
    rd(16'h0089, v, u); check({63'd0, u}, 64'd1, "R9 unaligned flag");

    rd(16'h0030, v, u);
    repeat (3) @(negedge clk);
    check(busRdata, 64'h800, "R11 rdata holds");

    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] pick [12];
      pick = '{16'h0000, 16'h0008, 16'h0030, 16'h0088, 16'h00F0, 16'h0130,
               16'h2010, 16'h4010, 16'h2018, 16'h0100, 16'h0088, 16'h008C};
      @(negedge clk);
      busAddr = pick[$urandom_range(0, 11)];
      busWdata = {$urandom, $urandom};
      pwrCtlPresent = ($urandom_range(0, 3) != 0);
      case ($urandom_range(0, 2))
        0: begin busRd = 1'b1; busWr = 1'b0; end
        1: begin busRd = 1'b0; busWr = 1'b1; end
        default: begin busRd = 1'b0; busWr = 1'b0; end
      endcase
    end
    @(negedge clk); busRd = 1'b0; busWr = 1'b0;

    // R4 reset in mid-run clears an enabled window
    pwrCtlPresent = 1'b1;
    wr(16'h0088, 64'h0000_0000_0001_8001, u);
    check({63'd0, remapEn}, 64'd1, "R3 enable before reset");
    modelOn = 0;
    rstN = 1'b0;
    @(negedge clk); @(negedge clk);
    check({63'd0, remapEn}, 64'd0, "R4 enable after reset");
    check(remapBase, 64'd0, "R4 base after reset");
    rstN = 1'b1;
    rd(16'h0088, v, u); check(v, 64'd0, "R4 stored zero");
    summary();
  end
endmodule